// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two N-bit binary operands and a carry-in in one combinational pass. It has no clock and holds no state. The operands are cut into 4-bit groups. Each group forms a generate term (AND) and a propagate term (inclusive OR) for every bit. It derives its internal carries as flat sum-of-products expressions and reports a group generate/propagate pair. A second-level lookahead generator uses the same equations to turn up to four group pairs and the incoming carry into the carry entering each group.

Four groups under one generator form a 16-bit section. Wider adders chain sections, and each section's carry-out feeds the next section's carry-in. A width that is not a multiple of 16 ends in a short section: its missing group slots are filled with pass-through pairs. Besides the sum and the carry-out, the block reports the carry into the most significant bit. A wrapper can XOR that carry with the carry-out to flag signed overflow.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals the low N bits of x + y + cin for every combination of operands and carry-in.
- R2: `cout` equals bit N of x + y + cin, i.e. the carry out of bit N-1.
- R3: `c_msb` equals the carry into bit N-1, which is x[N-1] XOR y[N-1] XOR sum[N-1]; `c_msb` XOR `cout` is the signed overflow of the addition.
- R4: Bit positions where both operand bits are 1 give the right sum bit whatever the incoming carry. The propagate term is an inclusive OR, and the sum bit is built from the operand XOR, not from the propagate term.
- R5: With y = ~x and cin = 1, every group propagates. `sum` is all zeros and `cout` is 1, and each group's carry-out equals its generate OR (propagate AND carry-in).
- R6: With no bit generating and cin = 0, no carry is produced anywhere. For y = ~x and cin = 0, `sum` is all ones and `cout` is 0.
- R7: N must be a positive multiple of 4, and a width that is not rejected at elaboration. N = 4, 16, 24 and 32 all give correct results, including a final section with fewer than four groups.
- R8: A single carry generated at bit 0 travels the full width. With x = 1 and y all ones, `sum` is 0 and `cout` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | N | First operand |
| y | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of x + y + cin |
| cout | output | 1 | Carry out of bit N-1 |
| c_msb | output | 1 | Carry into bit N-1, for overflow detection |

## Verification
The bench goes after carries that cross a group boundary and carries that cross a section boundary. A generator that mixes up group indices or pads a short section wrongly would then give a sum that is off by a power of sixteen, or would drop the carry-out. It drives operand bit pairs that are both 1 with a carry-in. A design that took the sum from the OR propagate term would clear those sum bits. Full-propagate vectors (y = ~x) with either carry-in, and one generate at bit 0 feeding an all-ones operand, expose a carry chain that is cut or stuck. The carry into the top bit is compared against the value implied by the operand and sum bits. A design that tapped the wrong bit would disagree on vectors where only the sign position carries.

// File: rtl/cla_pkg.sv
package cla_pkg;
   localparam int unsigned GRP_W     = 4;
   localparam int unsigned SEC_GRPS  = 4;
   localparam int unsigned SEC_W     = GRP_W * SEC_GRPS;

   function automatic int unsigned sec_width(input int unsigned total, input int unsigned idx);
      int unsigned left;
      left = total - idx * SEC_W;
      return (left >= SEC_W) ? SEC_W : left;
   endfunction
endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead (
   input  logic [3:0] gen,
   input  logic [3:0] prop,
   input  logic       ci,
   output logic [3:0] co
);
   always_comb begin
      co[0] = gen[0] | (prop[0] & ci);
      co[1] = gen[1] | (prop[1] & gen[0]) | (prop[1] & prop[0] & ci);
      co[2] = gen[2] | (prop[2] & gen[1]) | (prop[2] & prop[1] & gen[0])
            | (prop[2] & prop[1] & prop[0] & ci);
      co[3] = gen[3] | (prop[3] & gen[2]) | (prop[3] & prop[2] & gen[1])
            | (prop[3] & prop[2] & prop[1] & gen[0])
            | (prop[3] & prop[2] & prop[1] & prop[0] & ci);
   end

   always_comb begin
      if (gen == 4'b0000 && !ci)
         AST_NO_SPURIOUS_CARRY: assert (co == 4'b0000)
            else $error("carry produced with no generate and no carry-in"); // R6
   end
endmodule

// File: rtl/cla_group.sv
module cla_group (
   input  logic [3:0] a,
   input  logic [3:0] b,
   input  logic       ci,
   output logic [3:0] s,
   output logic       co,
   output logic       c_in3,
   output logic       grp_g,
   output logic       grp_p
);
   logic [3:0] bit_g;
   logic [3:0] bit_p;
   logic [3:0] bit_c;
   logic [3:0] c_into;

   assign bit_g = a & b;
   assign bit_p = a | b;

   cla_lookahead u_bits (
      .gen  (bit_g),
      .prop (bit_p),
      .ci   (ci),
      .co   (bit_c)
   );

   assign c_into = {bit_c[2:0], ci};
   assign s      = a ^ b ^ c_into;
   assign co     = bit_c[3];
   assign c_in3  = bit_c[2];

   assign grp_p = &bit_p;
   assign grp_g = bit_g[3] | (bit_p[3] & bit_g[2]) | (bit_p[3] & bit_p[2] & bit_g[1])
                | (bit_p[3] & bit_p[2] & bit_p[1] & bit_g[0]);

   always_comb begin
      AST_GROUP_PAIR: assert (co == (grp_g | (grp_p & ci)))
         else $error("group carry-out disagrees with group generate/propagate"); // R5
   end
endmodule

// File: rtl/cla_section.sv
module cla_section #(
   parameter int unsigned GROUPS = 4
) (
   input  logic [4*GROUPS-1:0] a,
   input  logic [4*GROUPS-1:0] b,
   input  logic                ci,
   output logic [4*GROUPS-1:0] s,
   output logic                co,
   output logic                c_top
);
   localparam int unsigned W = 4 * GROUPS;

   if (GROUPS < 1 || GROUPS > 4) begin : g_bad_groups
      $error("cla_section: GROUPS must be 1..4");
   end

   logic [3:0]        la_g;
   logic [3:0]        la_p;
   logic [3:0]        la_c;
   logic [GROUPS-1:0] grp_co;
   logic [GROUPS-1:0] grp_c3;
   logic [GROUPS-1:0] grp_ci;

   for (genvar k = 0; k < 4; k++) begin : g_slot
      if (k < GROUPS) begin : g_real
         assign grp_ci[k] = (k == 0) ? ci : la_c[(k == 0) ? 0 : k-1];

         cla_group u_grp (
            .a     (a[4*k +: 4]),
            .b     (b[4*k +: 4]),
            .ci    (grp_ci[k]),
            .s     (s[4*k +: 4]),
            .co    (grp_co[k]),
            .c_in3 (grp_c3[k]),
            .grp_g (la_g[k]),
            .grp_p (la_p[k])
         );

         always_comb begin
            AST_GROUP_VS_LOOKAHEAD: assert (grp_co[k] == la_c[k])
               else $error("group %0d carry differs from second-level carry", k); // R5
            AST_TOP_BIT_CARRY: assert (grp_co[k] == ((a[4*k+3] & b[4*k+3])
                                       | ((a[4*k+3] | b[4*k+3]) & grp_c3[k])))
               else $error("group %0d carry into bit 3 inconsistent", k); // R3
         end
      end else begin : g_pad
         assign la_g[k] = 1'b0;
         assign la_p[k] = 1'b1;

         always_comb begin
            AST_PAD_PASS: assert (la_c[k] == la_c[k-1])
               else $error("padded slot %0d altered the carry", k); // R7
         end
      end
   end

   cla_lookahead u_gen (
      .gen  (la_g),
      .prop (la_p),
      .ci   (ci),
      .co   (la_c)
   );

   assign co    = la_c[3];
   assign c_top = grp_c3[GROUPS-1];

   always_comb begin
      AST_SECTION_SUM: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci}))
         else $error("section sum wrong"); // R1
   end
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
   parameter int unsigned N = 32
) (
   input  logic [N-1:0] x,
   input  logic [N-1:0] y,
   input  logic         cin,
   output logic [N-1:0] sum,
   output logic         cout,
   output logic         c_msb
);
   import cla_pkg::*;

   localparam int unsigned NSEC = (N + SEC_W - 1) / SEC_W;

   if (N < GRP_W || (N % GRP_W) != 0) begin : g_bad_width
      $error("cla_adder: N must be a positive multiple of 4");
   end

   logic [NSEC:0]   sec_c;
   logic [NSEC-1:0] sec_top;

   assign sec_c[0] = cin;

   for (genvar s = 0; s < NSEC; s++) begin : g_sec
      localparam int unsigned SW   = sec_width(N, s);
      localparam int unsigned LO   = s * SEC_W;
      localparam int unsigned TOPB = LO + SW - 1;

      cla_section #(.GROUPS(SW / GRP_W)) u_sec (
         .a     (x[LO +: SW]),
         .b     (y[LO +: SW]),
         .ci    (sec_c[s]),
         .s     (sum[LO +: SW]),
         .co    (sec_c[s+1]),
         .c_top (sec_top[s])
      );

      always_comb begin
         AST_SECTION_TOP: assert (sec_top[s] == (x[TOPB] ^ y[TOPB] ^ sum[TOPB]))
            else $error("section %0d top-bit carry wrong", s); // R3
      end
   end

   assign cout  = sec_c[NSEC];
   assign c_msb = sec_top[NSEC-1];

   always_comb begin
      AST_EXACT_SUM: assert ({cout, sum} == ({1'b0, x} + {1'b0, y} + {{N{1'b0}}, cin}))
         else $error("adder result wrong"); // R1
      AST_CARRY_OUT: assert (cout == ((x[N-1] & y[N-1]) | ((x[N-1] | y[N-1]) & c_msb)))
         else $error("carry-out inconsistent with sign-bit carry"); // R2
   end
endmodule

// File: tb/cla_adder_bench.sv
`timescale 1ns/1ps
module cla_adder_bench;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [31:0] tx;
   logic [31:0] ty;
   logic        tc;

   logic [31:0] s32; logic co32, cm32;
   logic [23:0] s24; logic co24, cm24;
   logic [15:0] s16; logic co16, cm16;
   logic [3:0]  s4;  logic co4,  cm4;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   cla_adder #(.N(32)) u_cla_adder (
      .x(tx), .y(ty), .cin(tc), .sum(s32), .cout(co32), .c_msb(cm32));
   cla_adder #(.N(24)) u_cla_adder_w24 (
      .x(tx[23:0]), .y(ty[23:0]), .cin(tc), .sum(s24), .cout(co24), .c_msb(cm24));
   cla_adder #(.N(16)) u_cla_adder_w16 (
      .x(tx[15:0]), .y(ty[15:0]), .cin(tc), .sum(s16), .cout(co16), .c_msb(cm16));
   cla_adder #(.N(4)) u_cla_adder_w4 (
      .x(tx[3:0]), .y(ty[3:0]), .cin(tc), .sum(s4), .cout(co4), .c_msb(cm4));

   task automatic chk(input int w, input logic [31:0] s_act, input logic co_act,
                      input logic cm_act, input string req);
      logic [31:0] mask;
      logic [32:0] full;
      logic [31:0] e_s;
      logic        e_co, e_cm;
      mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
      full = {1'b0, tx & mask} + {1'b0, ty & mask} + {32'b0, tc};
      e_s  = full[31:0] & mask;
      e_co = full[w];
      e_cm = tx[w-1] ^ ty[w-1] ^ full[w-1];
      n_chk++;
      if (s_act !== e_s || co_act !== e_co || cm_act !== e_cm) begin
         n_fail++;
         $display("FAIL %s (R1 R2 R3) w=%0d x=%h y=%h cin=%b: sum=%h cout=%b c_msb=%b expected sum=%h cout=%b c_msb=%b",
                  req, w, tx & mask, ty & mask, tc, s_act, co_act, cm_act, e_s, e_co, e_cm);
      end
   endtask

   task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic c,
                        input string req);
      @(negedge clk);
      tx = a; ty = b; tc = c;
      #2;
      chk(32, s32, co32, cm32, req);
      chk(24, {8'b0, s24}, co24, cm24, req);
      chk(16, {16'b0, s16}, co16, cm16, req);
      chk(4,  {28'b0, s4},  co4,  cm4,  req);
   endtask

   // all-zero inputs give all-zero outputs
   task automatic t_idle;
      apply(32'h0, 32'h0, 1'b0, "R1 zero");
   endtask

   // exhaustive at width 4 (other widths see the same low nibble)
   task automatic t_exhaustive4;
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++)
            for (int c = 0; c < 2; c++)
               apply(32'(a), 32'(b), c[0], "R7 exhaustive4");
   endtask

   // both operand bits set, with carry-in
   task automatic t_both_ones;
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R4 allones_cin1");
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R4 allones_cin0");
      apply(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1, "R4 alt_same");
      apply(32'h5555_5555, 32'h5555_5555, 1'b1, "R4 alt_same5");
   endtask

   // full propagate chains
   task automatic t_propagate;
      apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R5 alt_cin1");
      apply(32'h1234_5678, ~32'h1234_5678, 1'b1, "R5 comp_cin1");
      apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R6 alt_cin0");
      apply(32'h0F0F_F0F0, ~32'h0F0F_F0F0, 1'b0, "R6 comp_cin0");
   endtask

   // single generate at bit 0 rippling through everything
   task automatic t_long_carry;
      apply(32'h0000_0001, 32'hFFFF_FFFF, 1'b0, "R8 gen0");
      apply(32'h0000_0000, 32'hFFFF_FFFF, 1'b1, "R8 cin_chain");
      apply(32'h0000_0008, 32'h0000_0008, 1'b0, "R8 group_cross");
      apply(32'h0000_8000, 32'h0000_8000, 1'b0, "R8 section_cross");
   endtask

   // sign-position carry corner cases
   task automatic t_sign_carry;
      apply(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, "R3 pos_ovf");
      apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R3 neg_ovf");
      apply(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, "R3 max_pos");
      apply(32'h0000_7FFF, 32'h0000_0001, 1'b0, "R3 w16_ovf");
   endtask

   task automatic t_random;
      for (int i = 0; i < 400; i++)
         apply($urandom, $urandom, 1'($urandom), "R1 random");
   endtask

   initial begin
      tx = '0; ty = '0; tc = 1'b0;
      t_idle();
      t_exhaustive4();
      t_both_ones();
      t_propagate();
      t_long_carry();
      t_sign_carry();
      t_random();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule